// File: doc/BRIEF.md
# Page-Hit Detecting DRAM Controller

This controller connects a processor's simplified 32-bit memory bus to a single DRAM bank that is one word (4 bytes) wide and holds 128 Mbytes. The bank is addressed by a 25-bit word address. The controller accepts one read or write per bus cycle. It splits the word address into a row part and a column part, and keeps the row strobe asserted after each access. The next request can therefore be compared against the row that is still open.

When a request's row equals the open row, the controller runs a column-only access: the row phase is skipped and only the new column is strobed. A request to any other row, or the first request after reset, needs a full cycle. If a row is open, that cycle first precharges the bank, then strobes the row and then the column. The hit decision is a single equality compare against a registered row. It is made in the cycle the request is sampled, so it fits in the half clock the bus allows.

All DRAM timing is expressed in whole clocks by three parameters: precharge, row-to-column delay and column access. Wait states appear on the bus as extra cycles before the one-cycle ready pulse.

Top module: `dram_page_ctrl`

## Requirements
- R1: While reset is held, ras_n, cas_n and we_n are high, rdy is low, and no row is open, so the first request after reset is handled as a miss with no row open.
- R2: The row is addr[ADDR_W-1:COL_W] and the column is addr[COL_W-1:0]. A request is a hit exactly when a row is open and all of its row bits equal the open row.
- R3: A hit drives cas_n low with the column on dram_addr for T_CAS cycles, starting the cycle after the request is sampled, with ras_n kept low. rdy is high in the following cycle, T_CAS+1 cycles after sampling.
- R4: A miss with no row open drives ras_n low with the row on dram_addr for T_RCD cycles, then runs the column phase of R3. rdy follows T_RCD+T_CAS+1 cycles after sampling.
- R5: A miss while a row is open first holds ras_n high for T_PRE cycles, then proceeds as in R4. rdy follows T_PRE+T_RCD+T_CAS+1 cycles after sampling.
- R6: Once a row has been opened, ras_n stays low in idle cycles between accesses.
- R7: rdy is a single-cycle pulse. A request is accepted in an idle cycle or in the rdy cycle itself. A request sampled during the precharge, row or column phases is ignored.
- R8: we_n is low only during the column phase of a write. During that phase dram_wdata carries the write data latched when the request was sampled.
- R9: rdata is loaded from dram_rdata in the last column cycle and is valid while rdy is high for a read.
- R10: cas_n is low only while ras_n is low, and never in the cycle in which ras_n falls.
- R11: A burst of 4 sequential word addresses within one row costs one miss and then three hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Request strobe, sampled on the rising edge |
| wr | input | 1 | 1 for write, 0 for read |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid with rdy |
| rdy | output | 1 | Access complete, one cycle |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| dram_addr | output | MA_W | Multiplexed row/column address |
| dram_wdata | output | DATA_W | Data to the DRAM |
| dram_rdata | input | DATA_W | Data from the DRAM |

## Verification
The hardest situations to reach from the ports are two. One is a request that arrives while the controller is busy, which must be dropped. The other is a request that crosses a row boundary by a single column step, which must take the precharge path. The stimulus produces both on purpose. It strobes a second request one cycle into an access, and it steps from the last column of a row to the first column of the next row. A random stream drawn from only four rows then mixes hits, open-row misses and requests placed in the ready cycle, and a behavioural model checks the strobes every cycle.

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl #(
  parameter int ADDR_W = 25,
  parameter int COL_W  = 12,
  parameter int DATA_W = 32,
  parameter int T_PRE  = 2,
  parameter int T_RCD  = 2,
  parameter int T_CAS  = 2,
  localparam int ROW_W = ADDR_W - COL_W,
  localparam int MA_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdy,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [MA_W-1:0]   dram_addr,
  output logic [DATA_W-1:0] dram_wdata,
  input  logic [DATA_W-1:0] dram_rdata
);

  localparam int TMAX  = (T_PRE > T_RCD) ? ((T_PRE > T_CAS) ? T_PRE : T_CAS)
                                         : ((T_RCD > T_CAS) ? T_RCD : T_CAS);
  localparam int CNT_W = (TMAX < 2) ? 1 : $clog2(TMAX);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_ROW, S_COL, S_DONE} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [ROW_W-1:0] open_row;
  logic [COL_W-1:0] col_q;
  logic             row_valid, wr_q;
  logic [DATA_W-1:0] wdata_q;

  wire [ROW_W-1:0] in_row = addr[ADDR_W-1:COL_W];
  wire free  = (st == S_IDLE) || (st == S_DONE);
  wire start = req && free;
  wire hit   = row_valid && (in_row == open_row);
  wire last  = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      open_row  <= '0;
      col_q     <= '0;
      row_valid <= 1'b0;
      wr_q      <= 1'b0;
      wdata_q   <= '0;
      rdata     <= '0;
    end else begin
      case (st)
        S_IDLE, S_DONE: begin
          st <= S_IDLE;
          if (start) begin
            col_q   <= addr[COL_W-1:0];
            wr_q    <= wr;
            wdata_q <= wdata;
            if (hit) begin
              st  <= S_COL;
              cnt <= CNT_W'(T_CAS - 1);
            end else begin
              open_row  <= in_row;
              row_valid <= 1'b1;
              if (row_valid) begin
                st  <= S_PRE;
                cnt <= CNT_W'(T_PRE - 1);
              end else begin
                st  <= S_ROW;
                cnt <= CNT_W'(T_RCD - 1);
              end
            end
          end
        end
        S_PRE: begin
          if (last) begin
            st  <= S_ROW;
            cnt <= CNT_W'(T_RCD - 1);
          end else cnt <= cnt - 1'b1;
        end
        S_ROW: begin
          if (last) begin
            st  <= S_COL;
            cnt <= CNT_W'(T_CAS - 1);
          end else cnt <= cnt - 1'b1;
        end
        S_COL: begin
          if (last) begin
            st    <= S_DONE;
            rdata <= dram_rdata;
          end else cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ras_n      = (st == S_PRE) || ((st == S_IDLE) && !row_valid);
  assign cas_n      = (st != S_COL);
  assign we_n       = !((st == S_COL) && wr_q);
  assign rdy        = (st == S_DONE);
  assign dram_addr  = (st == S_COL) ? MA_W'(col_q) : MA_W'(open_row);
  assign dram_wdata = wdata_q;

endmodule

module dram_page_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic rdy,
  input logic ras_n,
  input logic cas_n,
  input logic we_n
);
  // R10
  cas_under_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);
  // R10
  ras_cas_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> cas_n);
  // R7
  rdy_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |=> !rdy);
  // R6
  rdy_row_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |-> (!ras_n && cas_n));
  // R8
  we_in_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !cas_n);
  // R5
  pre_after_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> $past(cas_n));
endmodule

bind dram_page_ctrl dram_page_ctrl_chk u_chk (.*);

// File: tb/dram_page_ctrl_bench.sv
module dram_page_ctrl_bench;
  localparam int ADDR_W = 25, COL_W = 12, DATA_W = 32;
  localparam int T_PRE = 2, T_RCD = 2, T_CAS = 2;
  localparam int MA_W = 13;
  localparam logic [31:0] KEY = 32'h5A00_0000;

  typedef struct {
    bit ras, cas, we, rdy, ck_a;
    int a;
    int dsel;
    logic [31:0] d;
    string tag;
  } ent_t;

  logic clk = 0, rst_n = 1, req = 0, wr = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0, rdata, dram_wdata, dram_rdata;
  logic rdy, ras_n, cas_n, we_n;
  logic [MA_W-1:0] dram_addr;
  logic [ADDR_W-1:0] cur_addr = '0;

  int n_chk = 0, n_fail = 0;
  bit ended = 0;

  always #10 clk = ~clk;

  dram_page_ctrl #(.ADDR_W(ADDR_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .T_PRE(T_PRE), .T_RCD(T_RCD), .T_CAS(T_CAS)) u_dram_page_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rdy(rdy), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .dram_addr(dram_addr), .dram_wdata(dram_wdata), .dram_rdata(dram_rdata));

  assign dram_rdata = KEY ^ {7'b0, cur_addr};

  ent_t exp_q[$];
  ent_t cur;
  bit   m_valid = 0;
  int   m_row = 0;

  function automatic ent_t mk(bit ras, bit cas, bit we, bit r, bit ck_a, int a,
                              int dsel, logic [31:0] d, string tag);
    ent_t e;
    e.ras = ras; e.cas = cas; e.we = we; e.rdy = r; e.ck_a = ck_a; e.a = a;
    e.dsel = dsel; e.d = d; e.tag = tag;
    return e;
  endfunction

  initial cur = mk(1, 1, 1, 0, 0, 0, 0, 0, "R1");

  // behavioural model: an accepted request expands into its expected cycles
  always @(posedge clk) begin
    if (!rst_n) begin
      exp_q.delete();
      m_valid = 0;
      cur = mk(1, 1, 1, 0, 0, 0, 0, 0, "R1");
    end else begin
      if (exp_q.size() == 0 && req) begin
        int row, col;
        row = int'(addr) >> COL_W;
        col = int'(addr) & ((1 << COL_W) - 1);
        cur_addr = addr;
        if (!(m_valid && row == m_row)) begin
          if (m_valid)
            for (int i = 0; i < T_PRE; i++) exp_q.push_back(mk(1, 1, 1, 0, 0, 0, 0, 0, "R5"));
          for (int i = 0; i < T_RCD; i++) exp_q.push_back(mk(0, 1, 1, 0, 1, row, 0, 0, "R4"));
          m_valid = 1;
          m_row = row;
        end
        for (int i = 0; i < T_CAS; i++)
          exp_q.push_back(mk(0, 0, !wr, 0, 1, col, wr ? 1 : 0, wdata, wr ? "R8" : "R3"));
        exp_q.push_back(mk(0, 1, 1, 1, 0, 0, wr ? 0 : 2, KEY ^ {7'b0, addr}, wr ? "R7" : "R9"));
      end
      if (exp_q.size() != 0) cur = exp_q.pop_front();
      else cur = mk(!m_valid, 1, 1, 0, 0, 0, 0, 0, "R6");
    end
  end

  always @(negedge clk) begin
    if (rst_n && !ended) begin
      bit ok;
      ok = (ras_n == cur.ras) && (cas_n == cur.cas) && (we_n == cur.we) && (rdy == cur.rdy);
      if (cur.ck_a && int'(dram_addr) != cur.a) ok = 0;
      if (cur.dsel == 1 && dram_wdata != cur.d) ok = 0;
      if (cur.dsel == 2 && rdata != cur.d) ok = 0;
      n_chk++;
      if (!ok) begin
        n_fail++;
        $display("FAIL %s: got ras=%b cas=%b we=%b rdy=%b ma=%0h wd=%h rd=%h exp ras=%b cas=%b we=%b rdy=%b ma=%0h d=%h",
                 cur.tag, ras_n, cas_n, we_n, rdy, dram_addr, dram_wdata, rdata,
                 cur.ras, cur.cas, cur.we, cur.rdy, cur.a, cur.d);
      end
    end
  end

  task automatic check(bit cond, string tag, int act, int expv);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic wait_free();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic do_req(logic [ADDR_W-1:0] a, bit w, logic [31:0] d, int lat, string tag);
    int n;
    wait_free();
    req = 1; addr = a; wr = w; wdata = d;
    @(negedge clk);
    req = 0;
    n = 1;
    while (!rdy && n < 40) begin
      @(negedge clk);
      n++;
    end
    check(n == lat, tag, n, lat);
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  localparam int L_HIT  = T_CAS + 1;
  localparam int L_CLS  = T_RCD + T_CAS + 1;
  localparam int L_OPEN = T_PRE + T_RCD + T_CAS + 1;

  initial begin
    #1 rst_n = 0;
    repeat (3) @(negedge clk);
    // R1
    check(ras_n && cas_n && we_n && !rdy, "R1", {ras_n, cas_n, we_n, rdy}, 4'b1110);
    rst_n = 1;
    @(negedge clk);
    // R1 R4: first access after reset is a closed-row miss
    do_req(25'h0001_123, 0, 0, L_CLS, "R4");
    // R3 R6: same row hit
    do_req(25'h0001_456, 0, 0, L_HIT, "R3");
    // R11: 4-word burst in row 5
    do_req((25'd5 << COL_W) | 25'h010, 0, 0, L_OPEN, "R11");
    for (int i = 1; i < 4; i++)
      do_req((25'd5 << COL_W) | 25'(16 + i), 0, 0, L_HIT, "R11");
    // R8: write hit and write miss
    do_req((25'd5 << COL_W) | 25'h020, 1, 32'hDEAD_BEEF, L_HIT, "R8");
    do_req((25'd9 << COL_W) | 25'h020, 1, 32'h1234_5678, L_OPEN, "R8");
    // R2: last column, then next column crosses into the next row
    do_req((25'd9 << COL_W) | 25'hFFF, 0, 0, L_HIT, "R2");
    do_req((25'd10 << COL_W), 0, 0, L_OPEN, "R2");
    // R2: same column, different row
    do_req((25'd11 << COL_W), 0, 0, L_OPEN, "R2");
    // R7: request in the rdy cycle is accepted at once
    do_req((25'd11 << COL_W) | 25'h001, 0, 0, L_HIT, "R7");
    req = 1; addr = (25'd11 << COL_W) | 25'h002; wr = 0;
    @(negedge clk);
    req = 0;
    check(!cas_n, "R7", cas_n, 0);
    // R7: request while busy is ignored (model checks strobes and row)
    wait_free();
    req = 1; addr = (25'd12 << COL_W) | 25'h003; wr = 0;
    @(negedge clk);
    addr = (25'd13 << COL_W) | 25'h004;
    @(negedge clk);
    req = 0;
    wait_free();
    do_req((25'd12 << COL_W) | 25'h005, 0, 0, L_HIT, "R7");
    // random mix over four rows, including requests while busy
    for (int i = 0; i < 600; i++) begin
      req   = ($urandom % 2) == 0;
      addr  = {13'($urandom % 4), 12'($urandom % 8)};
      wr    = ($urandom % 3) == 0;
      wdata = $urandom;
      @(negedge clk);
    end
    req = 0;
    wait_free();
    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule